// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads at most two descriptors from a page table in memory. A request carries the virtual address, an access kind (load, store or fetch), a user flag and the table base. The walker takes the request only while it is idle. It issues one single-cycle memory read, waits for the matching response, and then either finishes or issues a second read. When the walk is over it raises a one-cycle completion pulse. The pulse carries one of two things: a physical address with a large-page flag, or a five-bit fault code.

The level-one descriptor either maps a 4 MB large page directly or points at a level-two table of 4 KB page entries. Both kinds of descriptor carry load, store and fetch grant bits. The walker checks these bits only for user accesses; a non-user access is never refused for lack of a grant. A descriptor whose type field is not recognised ends the walk with a dedicated fault code. Nothing in the block stores translations; a caller that wants caching keeps it outside.

The controller has six states:

| State | What happens | Next state |
| --- | --- | --- |
| S_IDLE | Waits for a request | S_DIR_ISSUE when a request arrives |
| S_DIR_ISSUE | Issues the level-one read | S_DIR_WAIT, always |
| S_DIR_WAIT | Waits for the level-one response | S_LEAF_ISSUE for a present table pointer, otherwise S_REPORT |
| S_LEAF_ISSUE | Issues the level-two read | S_LEAF_WAIT, always |
| S_LEAF_WAIT | Waits for the level-two response | S_REPORT |
| S_REPORT | Drives the one-cycle result pulse | S_IDLE, always |

Top module: `ptw_walker`

## Requirements
- R1: The level-one read address is the table base with bits [11:0] cleared, with virtual address bits [31:22] placed at address bits [11:2] and address bits [1:0] zero.
- R2: A level-one descriptor with type bits [1:0] = 2'b01 and present bit 2 set is a large page. The walk ends with physical address {desc[31:22], va[21:0]} and done_big = 1, after the permission check of R7.
- R3: A large-page descriptor (type 2'b01) whose present bit is clear ends the walk with fault code 0x0B.
- R4: A level-one descriptor with type 2'b00 (table pointer) whose present bit is clear ends the walk with fault code 0x05.
- R5: For a present table pointer, the level-two read address is {desc[31:12], va[21:12], 2'b00}.
- R6: A level-two entry whose present bit is clear faults with 0x08. A present entry of type 2'b00 ends the walk with physical address {entry[31:12], va[11:0]} and done_big = 0.
- R7: Access kinds are encoded as 0 = load, 1 = store, 2 = fetch. The grant bits are 8 = load, 7 = store and 6 = fetch. A user access whose grant bit is clear faults with 0x11 (load), 0x12 (store) or 0x13 (fetch). Access kind 3 is never refused.
- R8: A non-user access is never refused for lack of a grant bit.
- R9: An unrecognised type ends the walk with fault code 0x1F. At level one the unrecognised types are 2'b10 and 2'b11. At level two any present entry with a type other than 2'b00 is unrecognised.
- R10: The walker has at most one memory read outstanding. Each read request lasts exactly one cycle, and req_ready is high only while idle.
- R11: done_valid lasts exactly one cycle. It rises the cycle after the final response is taken. A successful result reports done_code = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when req_ready is high |
| req_ready | output | 1 | High while the walker is idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | User-mode access, enables the grant check |
| tbl_base | input | 32 | Level-one table base, captured with the request |
| mem_rd_valid | output | 1 | Single-cycle descriptor read request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | The walk ended with a fault |
| done_code | output | 5 | Fault code, zero on success |
| done_paddr | output | 32 | Physical address |
| done_big | output | 1 | 1 for a 4 MB page, 0 for a 4 KB page |

## Verification
The bench memory answers each read exactly one cycle after it sees the request. A walk that ends at level one then completes two cycles after the clock edge that takes the request, and a walk that reaches level two completes four cycles after it. Each expected item in the scoreboard records the acceptance cycle and the expected latency. The monitor compares the latency, the result fields and the fault code at the falling edge in which done_valid is high. The memory model also flags any read address that was not placed in the table, which checks the address formation.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int CODE_W = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_DIR_ISSUE, S_DIR_WAIT, S_LEAF_ISSUE, S_LEAF_WAIT, S_REPORT
    } walk_state_t;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [1:0] TY_TABLE = 2'b00;
    localparam logic [1:0] TY_BIG   = 2'b01;
    localparam logic [1:0] TY_SMALL = 2'b00;

    localparam logic [CODE_W-1:0] FC_NONE      = 5'h00;
    localparam logic [CODE_W-1:0] FC_TBL_ABS   = 5'h05;
    localparam logic [CODE_W-1:0] FC_LEAF_ABS  = 5'h08;
    localparam logic [CODE_W-1:0] FC_BIG_ABS   = 5'h0B;
    localparam logic [CODE_W-1:0] FC_NO_LOAD   = 5'h11;
    localparam logic [CODE_W-1:0] FC_NO_STORE  = 5'h12;
    localparam logic [CODE_W-1:0] FC_NO_FETCH  = 5'h13;
    localparam logic [CODE_W-1:0] FC_BAD_TYPE  = 5'h1F;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] dir_desc,
    output logic [VA_W-1:0] dir_addr,
    output logic [VA_W-1:0] leaf_addr
);
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int TOP_LO  = VA_W - IDX_W;
    localparam int MID_LO  = TOP_LO - IDX_W;

    assign dir_addr  = {base[VA_W-1:OFF_W], vaddr[VA_W-1:TOP_LO], 2'b00};
    assign leaf_addr = {dir_desc[VA_W-1:OFF_W], vaddr[TOP_LO-1:MID_LO], 2'b00};

    logic unused_bits;
    assign unused_bits = ^{base[OFF_W-1:0], vaddr[MID_LO-1:0], dir_desc[OFF_W-1:0], FRAME_W[0]};
endmodule

// File: rtl/ptw_desc_check.sv
module ptw_desc_check
    import ptw_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0]   desc,
    input  logic              at_leaf,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [1:0]        access,
    input  logic              user,
    output logic              descend,
    output logic              fault,
    output logic [CODE_W-1:0] code,
    output logic [VA_W-1:0]   paddr,
    output logic              big
);
    localparam int BIG_OFF   = 22;
    localparam int SMALL_OFF = 12;

    logic [1:0] kind;
    logic       present;
    logic       check_perm;

    assign kind    = desc[1:0];
    assign present = desc[2];

    always_comb begin
        descend    = 1'b0;
        code       = FC_NONE;
        paddr      = '0;
        big        = 1'b0;
        check_perm = 1'b0;
        if (!at_leaf) begin
            unique case (kind)
                TY_BIG: begin
                    if (!present) code = FC_BIG_ABS;
                    else begin
                        paddr      = {desc[VA_W-1:BIG_OFF], vaddr[BIG_OFF-1:0]};
                        big        = 1'b1;
                        check_perm = 1'b1;
                    end
                end
                TY_TABLE: begin
                    if (!present) code = FC_TBL_ABS;
                    else descend = 1'b1;
                end
                default: code = FC_BAD_TYPE;
            endcase
        end else begin
            if (!present)              code = FC_LEAF_ABS;
            else if (kind != TY_SMALL) code = FC_BAD_TYPE;
            else begin
                paddr      = {desc[VA_W-1:SMALL_OFF], vaddr[SMALL_OFF-1:0]};
                check_perm = 1'b1;
            end
        end
        if (check_perm && user) begin
            unique case (access)
                ACC_LOAD:  if (!desc[8]) code = FC_NO_LOAD;
                ACC_STORE: if (!desc[7]) code = FC_NO_STORE;
                ACC_FETCH: if (!desc[6]) code = FC_NO_FETCH;
                default:   ;
            endcase
        end
        fault = (code != FC_NONE);
    end

    logic unused_desc;
    assign unused_desc = ^{desc[11:9], desc[5:3]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_access,
    input  logic        req_user,
    input  logic [31:0] tbl_base,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done_valid,
    output logic        done_fault,
    output logic [4:0]  done_code,
    output logic [31:0] done_paddr,
    output logic        done_big
);
    walk_state_t state, nxt;

    logic [VA_W-1:0]   va_q, base_q, dir_desc_q;
    logic [1:0]        acc_q;
    logic              user_q;
    logic              res_fault, res_big;
    logic [CODE_W-1:0] res_code;
    logic [VA_W-1:0]   res_paddr;

    logic [VA_W-1:0]   dir_addr, leaf_addr;
    logic              dec_descend, dec_fault, dec_big;
    logic [CODE_W-1:0] dec_code;
    logic [VA_W-1:0]   dec_paddr;

    ptw_addr_gen #(.VA_W(VA_W)) u_addr (
        .base(base_q), .vaddr(va_q), .dir_desc(dir_desc_q),
        .dir_addr(dir_addr), .leaf_addr(leaf_addr)
    );

    ptw_desc_check #(.VA_W(VA_W)) u_check (
        .desc(mem_rsp_data), .at_leaf(state == S_LEAF_WAIT),
        .vaddr(va_q), .access(acc_q), .user(user_q),
        .descend(dec_descend), .fault(dec_fault), .code(dec_code),
        .paddr(dec_paddr), .big(dec_big)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (req_valid) nxt = S_DIR_ISSUE;
            S_DIR_ISSUE:  nxt = S_DIR_WAIT;
            S_DIR_WAIT:   if (mem_rsp_valid) nxt = dec_descend ? S_LEAF_ISSUE : S_REPORT;
            S_LEAF_ISSUE: nxt = S_LEAF_WAIT;
            S_LEAF_WAIT:  if (mem_rsp_valid) nxt = S_REPORT;
            S_REPORT:     nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    // captured request and walk result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            base_q     <= '0;
            acc_q      <= ACC_LOAD;
            user_q     <= 1'b0;
            dir_desc_q <= '0;
            res_fault  <= 1'b0;
            res_code   <= FC_NONE;
            res_paddr  <= '0;
            res_big    <= 1'b0;
        end else if (state == S_IDLE && req_valid) begin
            va_q   <= req_vaddr;
            base_q <= tbl_base;
            acc_q  <= req_access;
            user_q <= req_user;
        end else if ((state == S_DIR_WAIT || state == S_LEAF_WAIT) && mem_rsp_valid) begin
            if (state == S_DIR_WAIT) dir_desc_q <= mem_rsp_data;
            res_fault <= dec_fault;
            res_code  <= dec_code;
            res_paddr <= dec_paddr;
            res_big   <= dec_big;
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state == S_IDLE);
        mem_rd_valid = (state == S_DIR_ISSUE) || (state == S_LEAF_ISSUE);
        mem_rd_addr  = (state == S_LEAF_ISSUE) ? leaf_addr :
                       (state == S_DIR_ISSUE)  ? dir_addr  : '0;
        done_valid   = (state == S_REPORT);
        done_fault   = res_fault;
        done_code    = res_code;
        done_paddr   = res_paddr;
        done_big     = res_big;
    end

    AST_DIR_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIR_ISSUE) |-> (mem_rd_addr[11:2] == va_q[31:22] && mem_rd_addr[31:12] == base_q[31:12] && mem_rd_addr[1:0] == 2'b00)); // R1
    AST_BIG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault && done_big) |-> (done_paddr[21:0] == va_q[21:0])); // R2
    AST_LEAF_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAF_ISSUE) |-> (mem_rd_addr[11:2] == va_q[21:12] && mem_rd_addr[31:12] == dir_desc_q[31:12])); // R5
    AST_KERNEL_NO_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !user_q) |-> !(done_code == FC_NO_LOAD || done_code == FC_NO_STORE || done_code == FC_NO_FETCH)); // R8
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || done_valid) |-> !req_ready); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R11
    AST_OK_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (done_code == FC_NONE)); // R11
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        req_user = 1'b0;
    logic [31:0] tbl_base = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid, done_fault, done_big;
    logic [4:0]  done_code;
    logic [31:0] done_paddr;

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access), .req_user(req_user),
        .tbl_base(tbl_base), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_code(done_code),
        .done_paddr(done_paddr), .done_big(done_big)
    );

    typedef struct {
        logic        flt;
        logic [4:0]  code;
        logic [31:0] pa;
        logic        big;
        int          lat;
        int          t0;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [logic [31:0]];
    int          cyc = 0;
    int          compared = 0;
    int          mismatched = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    localparam logic [31:0] BASE = 32'h0010_0ABC;

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: answers one cycle after the request is seen
    always @(negedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            pend          <= 1'b0;
        end
        if (mem_rd_valid) begin
            compared = compared + 1;
            if (!mem.exists(mem_rd_addr)) begin
                mismatched = mismatched + 1;
                $display("FAIL R1/R5 read address: actual %h expected a placed table word", mem_rd_addr);
            end
            pend      <= 1'b1;
            pend_addr <= mem_rd_addr;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (done_valid) begin
            compared = compared + 1;
            if (sb.size() == 0) begin
                mismatched = mismatched + 1;
                $display("FAIL R11 unexpected done: actual pulse expected none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (done_fault !== e.flt || done_code !== e.code || (cyc - e.t0) != e.lat ||
                    (!e.flt && (done_paddr !== e.pa || done_big !== e.big))) begin
                    mismatched = mismatched + 1;
                    $display("FAIL %s: actual flt=%b code=%h pa=%h big=%b lat=%0d expected flt=%b code=%h pa=%h big=%b lat=%0d",
                             e.tag, done_fault, done_code, done_paddr, done_big, cyc - e.t0,
                             e.flt, e.code, e.pa, e.big, e.lat);
                end
            end
        end
    end

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc, input logic usr);
        exp_t        r;
        logic [31:0] d;
        logic [31:0] e;
        logic        perm;
        r.flt = 0; r.code = 5'h00; r.pa = '0; r.big = 0; r.lat = 2; r.t0 = 0; r.tag = "";
        perm = 0;
        d = rd({BASE[31:12], va[31:22], 2'b00});
        e = d;
        if (d[1:0] == 2'b01) begin
            if (!d[2]) r.code = 5'h0B;
            else begin r.pa = {d[31:22], va[21:0]}; r.big = 1; perm = 1; end
        end else if (d[1:0] == 2'b00) begin
            if (!d[2]) r.code = 5'h05;
            else begin
                r.lat = 4;
                e = rd({d[31:12], va[21:12], 2'b00});
                if (!e[2]) r.code = 5'h08;
                else if (e[1:0] != 2'b00) r.code = 5'h1F;
                else begin r.pa = {e[31:12], va[11:0]}; perm = 1; end
            end
        end else r.code = 5'h1F;
        if (perm && usr) begin
            if (acc == 2'd0 && !e[8]) r.code = 5'h11;
            if (acc == 2'd1 && !e[7]) r.code = 5'h12;
            if (acc == 2'd2 && !e[6]) r.code = 5'h13;
        end
        r.flt = (r.code != 5'h00);
        return r;
    endfunction

    task automatic run(input logic [31:0] va, input logic [1:0] acc, input logic usr, input string tag);
        exp_t e;
        while (sb.size() != 0) @(negedge clk);
        e = model(va, acc, usr);
        e.tag = tag;
        sb.push_back(e);
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_access = acc;
        req_user   = usr;
        tbl_base   = BASE;
        @(posedge clk);
        #1 sb[sb.size()-1].t0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        compared = compared + 1;
        if (req_ready !== 1'b0) begin
            mismatched = mismatched + 1;
            $display("FAIL R10 ready while busy: actual %b expected 0", req_ready);
        end
    endtask

    task automatic place_dir(input logic [31:0] va, input logic [31:0] d);
        mem[{BASE[31:12], va[31:22], 2'b00}] = d;
    endtask

    initial begin
        // level one
        place_dir(32'h1234_5678, 32'hC000_01C5);  // large page, all grants
        place_dir(32'h4000_0000, 32'h0000_0001);  // large page absent
        place_dir(32'h8000_1000, 32'h0030_0000);  // table pointer absent
        place_dir(32'h0040_3ABC, 32'h0030_0004);  // table pointer present
        place_dir(32'h0080_0000, 32'h0000_0002);  // type 10
        place_dir(32'h00C0_0000, 32'h0000_0003);  // type 11
        place_dir(32'h0100_0000, 32'hABC0_0045);  // large page, fetch only
        // level two
        mem[32'h0030_000C] = 32'h5555_51C4;
        mem[32'h0030_0010] = 32'h6666_6000;
        mem[32'h0030_0014] = 32'h7777_7004;
        mem[32'h0030_0018] = 32'h8888_8005;

        repeat (3) @(negedge clk);
        compared = compared + 1;
        if (req_ready !== 1'b1 || done_valid !== 1'b0 || mem_rd_valid !== 1'b0) begin
            mismatched = mismatched + 1;
            $display("FAIL R10 reset state: actual ready=%b done=%b rd=%b expected 1/0/0",
                     req_ready, done_valid, mem_rd_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        run(32'h1234_5678, 2'd0, 1'b1, "R2 large page user load");
        run(32'h1234_5678, 2'd1, 1'b1, "R2 large page user store");
        run(32'h1234_5678, 2'd2, 1'b0, "R1 large page kernel fetch");
        run(32'h4000_0000, 2'd0, 1'b1, "R3 large page absent");
        run(32'h8000_1000, 2'd0, 1'b0, "R4 table pointer absent");
        run(32'h0040_3ABC, 2'd0, 1'b1, "R5 small page load");
        run(32'h0040_3ABC, 2'd2, 1'b1, "R6 small page fetch");
        run(32'h0040_4000, 2'd1, 1'b1, "R6 leaf absent");
        run(32'h0040_5123, 2'd0, 1'b1, "R7 user load denied");
        run(32'h0040_5123, 2'd1, 1'b1, "R7 user store denied");
        run(32'h0040_5123, 2'd2, 1'b1, "R7 user fetch denied");
        run(32'h0040_5123, 2'd3, 1'b1, "R7 kind 3 never denied");
        run(32'h0040_5123, 2'd1, 1'b0, "R8 kernel store no grant");
        run(32'h0040_5123, 2'd0, 1'b0, "R8 kernel load no grant");
        run(32'h0100_0000, 2'd0, 1'b1, "R7 large page load denied");
        run(32'h0100_0ABC, 2'd2, 1'b1, "R7 large page fetch granted");
        run(32'h0100_0000, 2'd1, 1'b0, "R8 large page kernel store");
        run(32'h0040_6000, 2'd0, 1'b1, "R9 leaf bad type");
        run(32'h0080_0000, 2'd0, 1'b1, "R9 level one type 10");
        run(32'h00C0_0000, 2'd0, 1'b0, "R9 level one type 11");
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        compared = compared + 1;
        if (done_valid !== 1'b0 || req_ready !== 1'b1) begin
            mismatched = mismatched + 1;
            $display("FAIL R11 idle after walks: actual done=%b ready=%b expected 0/1", done_valid, req_ready);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched = mismatched + 1;
        $display("FAIL R11 watchdog: actual hung run expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule